// File: doc/BRIEF.md
# Packed Byte Unpack Execution Unit

This execution unit serves one family of packed-SIMD instructions that widen bytes into halfwords. Each cycle it can accept a decoded 32-bit instruction word and one source register value. For every 32-bit word of the source it chooses two of the four bytes, widens each to 16 bits by sign or zero extension, and puts the two halfwords back into the same word. The register width is a parameter and may be 32 or 64 bits. A 64-bit register is handled as two independent words.

The result, the destination register index and an illegal-encoding flag are registered. They appear one clock after the input. Encodings outside the family are flagged and produce a zero result, so the writeback stage never receives stale data. Reset is asynchronous and active-low. Its release is synchronised inside the unit, so the unit accepts input a few cycles after `rst_n` rises.

Top module: `pk_unpack_unit`

## Requirements
- R1: An input is in the group only when bits [31:25] equal 1010110, bits [14:12] equal 000 and bits [6:0] equal 1110111. Bits [19:15] have no effect on the result.
- R2: Bits [24:20] select the sign-extending variants as follows: 01000 takes bytes (1,0), 01001 takes (2,0), 01010 takes (3,0), 01011 takes (3,1) and 10011 takes (3,2).
- R3: Bits [24:20] select the zero-extending variants as follows: 01100 takes (1,0), 01101 takes (2,0), 01110 takes (3,0), 01111 takes (3,1) and 10111 takes (3,2).
- R4: For a variant that takes bytes (x,y), bits [15:0] of each result word hold byte y widened and bits [31:16] hold byte x widened. Byte k of a word is bits [8k+7:8k].
- R5: The sign-extending variants copy bit 7 of the chosen byte into the upper 8 bits of its halfword. The zero-extending variants put zeros there.
- R6: The same selection is applied to every 32-bit word of the source independently. With XLEN=64, the upper result word depends only on the upper source word.
- R7: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R8: A valid input that matches none of the ten encodings raises `out_illegal` together with `out_valid`, and `out_result` is zero in that cycle.
- R9: `out_rd` carries bits [11:7] of the instruction, with the same latency as the result.
- R10: While `rst_n` is low, `out_valid` and `out_illegal` are low, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operand present |
| in_instr | input | 32 | Instruction word |
| in_src | input | XLEN | Source register value |
| out_valid | output | 1 | Result present |
| out_illegal | output | 1 | Encoding not recognised |
| out_rd | output | 5 | Destination register index |
| out_result | output | XLEN | Unpacked result |

## Verification
Two functions can fall in the same cycle: the illegal-encoding path, which forces the result to zero, and a legal unpack issued right after it. The random stream mixes legal encodings with corrupted opcode, funct3, funct7 and selector fields back to back. Each output cycle is therefore compared against a bench model for both the flag and the data. A second overlap is reset asserted while `in_valid` is held high. There the bench requires `out_valid` and `out_illegal` to stay low, and requires clean results after reset is released.

// File: rtl/pk_unpack_pkg.sv
package pk_unpack_pkg;
  localparam logic [6:0] GRP_OPCODE = 7'b1110111;
  localparam logic [2:0] GRP_FUNCT3 = 3'b000;
  localparam logic [6:0] GRP_FUNCT7 = 7'b1010110;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RIDX_W   = 5;

  typedef struct packed {
    logic       legal;
    logic       sext;
    logic [1:0] hi_sel;
    logic [1:0] lo_sel;
  } unpk_ctrl_t;
endpackage

// File: rtl/pk_unpack_rst_sync.sv
module pk_unpack_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pk_unpack_decode.sv
module pk_unpack_decode
  import pk_unpack_pkg::*;
(
  input  logic [31:0] instr_i,
  output unpk_ctrl_t  ctrl_o
);
  logic       grp_hit;
  logic       sel_hit;
  logic [4:0] sel;

  assign sel     = instr_i[24:20];
  assign grp_hit = (instr_i[31:25] == GRP_FUNCT7) &&
                   (instr_i[14:12] == GRP_FUNCT3) &&
                   (instr_i[6:0]   == GRP_OPCODE);

  // Bit 2 of the selector separates sign from zero extension.
  always_comb begin
    sel_hit = 1'b1;
    ctrl_o  = '0;
    ctrl_o.sext = ~sel[2];
    unique casez (sel)
      5'b01?00: begin ctrl_o.hi_sel = 2'd1; ctrl_o.lo_sel = 2'd0; end
      5'b01?01: begin ctrl_o.hi_sel = 2'd2; ctrl_o.lo_sel = 2'd0; end
      5'b01?10: begin ctrl_o.hi_sel = 2'd3; ctrl_o.lo_sel = 2'd0; end
      5'b01?11: begin ctrl_o.hi_sel = 2'd3; ctrl_o.lo_sel = 2'd1; end
      5'b10?11: begin ctrl_o.hi_sel = 2'd3; ctrl_o.lo_sel = 2'd2; end
      default:  sel_hit = 1'b0;
    endcase
    ctrl_o.legal = grp_hit & sel_hit;
  end
endmodule

// File: rtl/pk_unpack_lane.sv
module pk_unpack_lane
  import pk_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  unpk_ctrl_t        ctrl_i,
  output logic [WORD_W-1:0] word_o
);
  logic [7:0] byte_hi;
  logic [7:0] byte_lo;
  logic [7:0] fill_hi;
  logic [7:0] fill_lo;

  assign byte_hi = word_i[{ctrl_i.hi_sel, 3'b000} +: 8];
  assign byte_lo = word_i[{ctrl_i.lo_sel, 3'b000} +: 8];
  assign fill_hi = {8{ctrl_i.sext & byte_hi[7]}};
  assign fill_lo = {8{ctrl_i.sext & byte_lo[7]}};
  assign word_o  = {fill_hi, byte_hi, fill_lo, byte_lo};
endmodule

// File: rtl/pk_unpack_unit.sv
module pk_unpack_unit
  import pk_unpack_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_instr,
  input  logic [XLEN-1:0]   in_src,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [RIDX_W-1:0] out_rd,
  output logic [XLEN-1:0]   out_result
);
  localparam int unsigned NWORDS = XLEN / WORD_W;

  logic             rst_n_int;
  unpk_ctrl_t       ctrl;
  logic [XLEN-1:0]  lane_res;

  logic              vld_d, vld_q;
  logic              ill_d, ill_q;
  logic              data_en;
  logic [XLEN-1:0]   res_d, res_q;
  logic [RIDX_W-1:0] rd_d, rd_q;

  pk_unpack_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pk_unpack_decode dec_i (
    .instr_i (in_instr),
    .ctrl_o  (ctrl)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_lane
    pk_unpack_lane lane_i (
      .word_i (in_src[w*WORD_W +: WORD_W]),
      .ctrl_i (ctrl),
      .word_o (lane_res[w*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    data_en = in_valid;
    vld_d   = in_valid;
    ill_d   = in_valid & ~ctrl.legal;
    res_d   = ctrl.legal ? lane_res : '0;
    rd_d    = in_instr[11:7];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      res_q <= '0;
      rd_q  <= '0;
    end else if (data_en) begin
      res_q <= res_d;
      rd_q  <= rd_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_illegal = ill_q;
  assign out_rd      = rd_q;
  assign out_result  = res_q;
endmodule

// File: rtl/pk_unpack_chk.sv
module pk_unpack_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     in_instr,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [4:0]      out_rd,
  input logic [XLEN-1:0] out_result
);
  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  illegal_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);
  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_result == '0));
  // R9
  rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_rd == $past(in_instr[11:7])));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid && !out_illegal);
    end
  end

  for (genvar h = 0; h < XLEN/16; h++) begin : g_hw
    // R5
    hw_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal) |->
        (out_result[h*16+8 +: 8] == 8'h00 || out_result[h*16+8 +: 8] == 8'hFF));
  end
endmodule

bind pk_unpack_unit pk_unpack_chk #(.XLEN(XLEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_instr    (in_instr),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_rd      (out_rd),
  .out_result  (out_result)
);

// File: tb/pk_unpack_unit_tb_top.sv
`timescale 1ns/1ps
module pk_unpack_unit_tb_top;
  localparam int unsigned XLEN = 64;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     in_instr;
  logic [XLEN-1:0] in_src;
  logic            out_valid;
  logic            out_illegal;
  logic [4:0]      out_rd;
  logic [XLEN-1:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pk_unpack_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_src(in_src), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [4:0] CODES [10] = '{5'b01000, 5'b01001, 5'b01010, 5'b01011, 5'b10011,
                                        5'b01100, 5'b01101, 5'b01110, 5'b01111, 5'b10111};

  function automatic logic [31:0] mk_instr(logic [4:0] code, logic [4:0] rd, logic [4:0] rs1);
    return {7'b1010110, code, rs1, 3'b000, rd, 7'b1110111};
  endfunction

  function automatic bit exp_legal(logic [31:0] ins);
    bit grp;
    bit hit;
    grp = (ins[31:25] == 7'b1010110) && (ins[14:12] == 3'b000) && (ins[6:0] == 7'b1110111);
    hit = 1'b0;
    for (int i = 0; i < 10; i++) if (ins[24:20] == CODES[i]) hit = 1'b1;
    return grp && hit;
  endfunction

  function automatic logic [XLEN-1:0] exp_res(logic [31:0] ins, logic [XLEN-1:0] src);
    logic [XLEN-1:0] r;
    int hi, lo;
    bit sg;
    logic [7:0] bh, bl;
    r = '0;
    if (!exp_legal(ins)) return r;
    case (ins[24:20])
      5'b01000, 5'b01100: begin hi = 1; lo = 0; end
      5'b01001, 5'b01101: begin hi = 2; lo = 0; end
      5'b01010, 5'b01110: begin hi = 3; lo = 0; end
      5'b01011, 5'b01111: begin hi = 3; lo = 1; end
      default:            begin hi = 3; lo = 2; end
    endcase
    sg = (ins[24:20] == 5'b01000) || (ins[24:20] == 5'b01001) || (ins[24:20] == 5'b01010) ||
         (ins[24:20] == 5'b01011) || (ins[24:20] == 5'b10011);
    for (int w = 0; w < XLEN/32; w++) begin
      bh = src[w*32 + hi*8 +: 8];
      bl = src[w*32 + lo*8 +: 8];
      r[w*32 +: 16]      = {(sg && bl[7]) ? 8'hFF : 8'h00, bl};
      r[w*32 + 16 +: 16] = {(sg && bh[7]) ? 8'hFF : 8'h00, bh};
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, then sample at the next falling edge (one register stage).
  task automatic issue(logic [31:0] ins, logic [XLEN-1:0] src, string req);
    logic [XLEN-1:0] er;
    bit el;
    in_valid = 1'b1; in_instr = ins; in_src = src;
    er = exp_res(ins, src);
    el = exp_legal(ins);
    @(negedge clk);
    chk(out_valid == 1'b1, {req, " R7 valid"}, XLEN'(out_valid), 1);
    chk(out_illegal == !el, {req, " R1/R8 illegal"}, XLEN'(out_illegal), XLEN'(!el));
    chk(out_rd == ins[11:7], {req, " R9 rd"}, XLEN'(out_rd), XLEN'(ins[11:7]));
    chk(out_result == er, {req, " result"}, out_result, er);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [XLEN-1:0] s;
    logic [31:0] ins;
    void'($urandom(32'd1234));
    rst_n = 1'b1; in_valid = 1'b0; in_instr = '0; in_src = '0;
    #2 rst_n = 1'b0;
    in_valid = 1'b1;
    in_instr = mk_instr(5'b01000, 5'd3, 5'd4);
    repeat (3) @(negedge clk);
    // R10: reset wins over a held valid input
    chk(!out_valid && !out_illegal, "R10 reset state", XLEN'({out_valid, out_illegal}), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid, "R7 idle after reset", XLEN'(out_valid), 0);

    s = 64'h80FF7F01_8203C4E5;
    // R2 signed variants, R3 zero variants, R4 order, R5 extension, R6 per word
    for (int i = 0; i < 10; i++)
      issue(mk_instr(CODES[i], 5'(i + 1), 5'd9), s, (i < 5) ? "R2 R4 R5 R6" : "R3 R4 R5 R6");
    // R4 distinct bytes so the order is visible
    issue(mk_instr(5'b01111, 5'd31, 5'd0), 64'h11223344_55667788, "R4 R3 order");
    // R1 rs1 field has no effect
    issue(mk_instr(5'b01011, 5'd7, 5'd31), s, "R1 rs1 free");
    // R8 illegal funct7 / funct3 / opcode / selector
    issue(mk_instr(5'b01000, 5'd5, 5'd1) ^ 32'h0200_0000, s, "R1 R8 funct7");
    issue(mk_instr(5'b01000, 5'd6, 5'd1) | 32'h0000_1000, s, "R1 R8 funct3");
    issue(mk_instr(5'b01000, 5'd8, 5'd1) ^ 32'h0000_0040, s, "R1 R8 opcode");
    issue(mk_instr(5'b11000, 5'd9, 5'd1), s, "R8 selector");
    issue(mk_instr(5'b01100, 5'd2, 5'd1), s, "R3 after illegal");
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_illegal, "R7 idle cycle", XLEN'(out_valid), 0);

    // R6 random mix with corrupted encodings, back to back
    for (int n = 0; n < 400; n++) begin
      ins = mk_instr(CODES[$urandom_range(0, 9)], 5'($urandom), 5'($urandom));
      if ($urandom_range(0, 4) == 0) ins ^= (32'h1 << $urandom_range(0, 31));
      s = {$urandom, $urandom};
      issue(ins, s, "R6 random");
      if ($urandom_range(0, 7) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R7 random gap", XLEN'(out_valid), 0);
      end
    end

    // R10 reset in the middle of traffic
    in_valid = 1'b1;
    in_instr = mk_instr(5'b11111, 5'd1, 5'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!out_valid && !out_illegal, "R10 mid-run reset", XLEN'({out_valid, out_illegal}), 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    issue(mk_instr(5'b10011, 5'd12, 5'd3), 64'h7F80_0000_0080_7F00, "R2 R10 after reset");
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule